// File: doc/BRIEF.md
# BT.656 Line Standard Detector

This block listens to an 8-bit ITU-R BT.656 byte stream and works out, line by line, whether the source is 525-line/60 Hz or 625-line/50 Hz interlaced video. It finds each timing reference code (a 3-byte preamble FF, 00, 00 followed by a status byte) and decodes the field, vertical-blanking and horizontal flags from that status byte. It also counts how many accepted bytes lie between the end-of-active-video code and the next start-of-active-video code. That horizontal blanking length is 268 bytes for 525/60 (858 pixel periods, 720 active, two bytes per pixel) and 280 bytes for 625/50 (864 pixel periods, 720 active). A small window around each length allows for sources that are slightly off.

Each measured length is put into one of three classes: 525/60, 625/50, or no match. A run filter moves the one-bit vertical-mode output only after the same standard has been seen on `LOCK_LINES` consecutive lines. A lock flag shows that the current output is confirmed. Detection runs only while the auto-detect enable is high and the horizontal-mode field selects the 720-active-pixel setting. At other times the mode bit keeps its value and the lock flag stays low.

The byte input is a valid/ready stream. The block is a pure observer, so `in_ready` is 1 in every cycle after reset and no upstream source is ever held back. A byte counts as accepted only in a cycle where `in_valid` is 1. Idle cycles can fall anywhere, even inside a timing reference code, and they are ignored.

Top module: `bt656_std_detect`

## Requirements
- R1: `in_ready` is 1 in every cycle after reset. A byte is accepted only when `in_valid` is 1. Bytes presented with `in_valid` at 0 are neither counted nor matched against a timing reference code.
- R2: A timing reference code is four consecutive accepted bytes FF, 00, 00, XY where XY bit 7 is 1. In the cycle after XY is accepted, `trs_f`, `trs_v` and `trs_h` take XY bits 6, 5 and 4, and they hold those values until the next code. An XY byte with bit 7 at 0 is not a code and leaves the flags unchanged.
- R3: The blanking length is the number of accepted bytes strictly between the XY byte of a code with H=1 (end of active video) and the FF byte of the next code with H=0 (start of active video). A start code with no end code before it (since the last start code) produces no measurement.
- R4: A length from 266 to 270 classifies as 525/60. A length from 278 to 282 classifies as 625/50. Any other length is no match, including a length that overflows the 12-bit counter, which saturates instead of wrapping.
- R5: `vmode` changes only in the cycle after the start code that completes `LOCK_LINES` (default 4) consecutive measurements of the same standard. It becomes 1 for 525/60 and 0 for 625/50.
- R6: `locked` rises together with that confirming update and stays 1 while further measurements match the same standard. A no-match measurement or a measurement of the other standard clears it in the following cycle.
- R7: While `auto_en` is 0 or `hmode` is not 2'b00 (the 720-active-pixel setting), `vmode` holds, `locked` is 0 from the next cycle on, and the consecutive-line run restarts. After detection is enabled again, `LOCK_LINES` fresh matching lines are needed.
- R8: After reset, `vmode`, `locked`, `trs_f`, `trs_v` and `trs_h` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Always 1 after reset; the block never back-pressures |
| in_data | input | 8 | BT.656 byte stream |
| auto_en | input | 1 | Enables automatic standard detection |
| hmode | input | 2 | Horizontal mode; 2'b00 selects 720 active pixels |
| vmode | output | 1 | Detected standard: 1 = 525/60, 0 = 625/50 |
| locked | output | 1 | Current `vmode` is confirmed by consecutive lines |
| trs_f | output | 1 | Field flag from the last timing reference code |
| trs_v | output | 1 | Vertical blanking flag from the last code |
| trs_h | output | 1 | H flag from the last code (1 = end of active video) |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, centre lengths 268 and 280 with a tolerance of 2, and a four-line confirmation run. With these values, both edges of each acceptance window and the lengths just outside them can be reached with short directed lines. The confirmation run is short enough to go through several switches of standard, as well as a run broken by a disable pulse. Because the counter is 12 bits, an end code followed by 4364 blanking bytes fits in the run time. Had the counter wrapped, that gap would have landed inside the 525/60 window, so the test separates saturation from wrap-around.

// File: rtl/bt656_det_pkg.sv
package bt656_det_pkg;

  // Classification of one measured blanking interval
  typedef enum logic [1:0] {
    STD_NONE = 2'd0,
    STD_525  = 2'd1,
    STD_625  = 2'd2
  } std_e;

  // Flags carried in the status byte of a timing reference code
  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_flags_t;

  localparam int unsigned PREAMBLE_LEN = 3;
  localparam logic [7:0]  PRE_FIRST    = 8'hFF;
  localparam logic [7:0]  PRE_REST     = 8'h00;

endpackage

// File: rtl/bt656_trs_finder.sv
module bt656_trs_finder
  import bt656_det_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       trs_hit,
  output trs_flags_t trs_xy,
  output trs_flags_t flags_q
);

  localparam int unsigned PRE = PREAMBLE_LEN;

  // hist[0] is the most recently accepted byte
  logic [PRE-1:0][7:0] hist;
  logic [PRE-1:0]      stage_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (in_valid) begin
      for (int i = PRE - 1; i > 0; i--) begin
        hist[i] <= hist[i-1];
      end
      hist[0] <= in_data;
    end
  end

  // Oldest stage must hold FF, the younger ones 00
  for (genvar g = 0; g < PRE; g++) begin : g_stage
    localparam logic [7:0] EXP = (g == PRE - 1) ? PRE_FIRST : PRE_REST;
    assign stage_ok[g] = (hist[g] == EXP);
  end

  assign trs_xy  = '{f: in_data[6], v: in_data[5], h: in_data[4]};
  assign trs_hit = in_valid && (&stage_ok) && in_data[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (trs_hit) begin
      flags_q <= trs_xy;
    end
  end

  // R2: flags take the decoded status bits one cycle after a code
  a_r2_flags_follow_xy: assert property (@(posedge clk) disable iff (!rst_n)
    trs_hit |=> (flags_q == $past(trs_xy)));

  // R2: flags hold when no code was found
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trs_hit |=> $stable(flags_q));

endmodule

// File: rtl/bt656_blank_counter.sv
module bt656_blank_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             trs_hit,
  input  logic             trs_is_eav,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_len
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  // Bytes of the start code counted before its XY byte: FF, 00, 00
  localparam logic [CNT_W-1:0] PRE_BYTES = CNT_W'(3);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (trs_hit && trs_is_eav) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (trs_hit) begin
      armed <= 1'b0;
    end else if (in_valid && armed && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // The count includes the start code's preamble; remove it
  assign meas_valid = trs_hit && !trs_is_eav && armed;
  assign meas_len   = cnt - PRE_BYTES;

  // R3: an end code restarts the count
  a_r3_restart_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
    (trs_hit && trs_is_eav) |=> (cnt == '0));

  // R1: idle cycles never advance the count
  a_r1_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));

endmodule

// File: rtl/bt656_std_classifier.sv
module bt656_std_classifier
  import bt656_det_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned LEN_525 = 268,
  parameter int unsigned LEN_625 = 280,
  parameter int unsigned TOL     = 2
) (
  input  logic [CNT_W-1:0] meas_len,
  output std_e             meas_std
);

  localparam int unsigned N_STD = 2;
  logic [N_STD-1:0] hit;

  for (genvar g = 0; g < N_STD; g++) begin : g_win
    localparam int unsigned CENTRE = (g == 0) ? LEN_525 : LEN_625;
    localparam logic [CNT_W-1:0] LO = CNT_W'(CENTRE - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(CENTRE + TOL);
    assign hit[g] = (meas_len >= LO) && (meas_len <= HI);
  end

  always_comb begin
    if (hit[0]) begin
      meas_std = STD_525;
    end else if (hit[1]) begin
      meas_std = STD_625;
    end else begin
      meas_std = STD_NONE;
    end
  end

endmodule

// File: rtl/bt656_mode_filter.sv
module bt656_mode_filter
  import bt656_det_pkg::*;
#(
  parameter int unsigned LOCK_LINES = 4,
  parameter logic        VMODE_RST  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_ok,
  input  logic meas_valid,
  input  std_e meas_std,
  output logic vmode,
  output logic locked
);

  localparam int unsigned RUN_W = $clog2(LOCK_LINES + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_LINES);

  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] run_inc;
  std_e             prev;
  logic             confirm;

  always_comb begin
    if (meas_std == prev) begin
      run_inc = (run == RUN_TOP) ? run : run + 1'b1;
    end else begin
      run_inc = RUN_W'(1);
    end
    confirm = (meas_std != STD_NONE) && (run_inc >= RUN_TOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmode  <= VMODE_RST;
      locked <= 1'b0;
      run    <= '0;
      prev   <= STD_NONE;
    end else if (!en_ok) begin
      locked <= 1'b0;
      run    <= '0;
      prev   <= STD_NONE;
    end else if (meas_valid) begin
      if (meas_std == STD_NONE) begin
        locked <= 1'b0;
        run    <= '0;
        prev   <= STD_NONE;
      end else begin
        prev   <= meas_std;
        run    <= run_inc;
        locked <= confirm;
        if (confirm) begin
          vmode <= (meas_std == STD_525);
        end
      end
    end
  end

  // R7: disabled detection leaves the lock flag low
  a_r7_disabled_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> !locked);

  // R7: disabled detection holds the mode bit
  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> $stable(vmode));

  // R5: the mode bit moves only right after an enabled measurement
  a_r5_vmode_only_on_meas: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vmode) |-> $past(meas_valid && en_ok));

  // R6: lock rises only after a matching measurement
  a_r6_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_valid && (meas_std != STD_NONE)));

endmodule

// File: rtl/bt656_std_detect.sv
module bt656_std_detect
  import bt656_det_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned LEN_525    = 268,
  parameter int unsigned LEN_625    = 280,
  parameter int unsigned TOL        = 2,
  parameter int unsigned LOCK_LINES = 4,
  parameter int unsigned HMODE_W    = 2,
  parameter int unsigned HMODE_720  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               auto_en,
  input  logic [HMODE_W-1:0] hmode,
  output logic               vmode,
  output logic               locked,
  output logic               trs_f,
  output logic               trs_v,
  output logic               trs_h
);

  localparam logic [HMODE_W-1:0] HSEL_720 = HMODE_W'(HMODE_720);

  logic             trs_hit;
  trs_flags_t       trs_xy;
  trs_flags_t       flags_q;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_len;
  std_e             meas_std;
  logic             en_ok;

  // Observer only: every byte is taken
  assign in_ready = 1'b1;
  assign en_ok    = auto_en && (hmode == HSEL_720);

  bt656_trs_finder u_finder (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .trs_hit  (trs_hit),
    .trs_xy   (trs_xy),
    .flags_q  (flags_q)
  );

  bt656_blank_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .trs_hit    (trs_hit),
    .trs_is_eav (trs_xy.h),
    .meas_valid (meas_valid),
    .meas_len   (meas_len)
  );

  bt656_std_classifier #(
    .CNT_W   (CNT_W),
    .LEN_525 (LEN_525),
    .LEN_625 (LEN_625),
    .TOL     (TOL)
  ) u_classify (
    .meas_len (meas_len),
    .meas_std (meas_std)
  );

  bt656_mode_filter #(
    .LOCK_LINES (LOCK_LINES),
    .VMODE_RST  (1'b0)
  ) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_ok      (en_ok),
    .meas_valid (meas_valid),
    .meas_std   (meas_std),
    .vmode      (vmode),
    .locked     (locked)
  );

  assign trs_f = flags_q.f;
  assign trs_v = flags_q.v;
  assign trs_h = flags_q.h;

  // R1: the stream is never back-pressured
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

endmodule

// File: tb/test_bt656_std_detect.sv
`timescale 1ns/1ps
module test_bt656_std_detect;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h10;
  logic       auto_en = 1'b1;
  logic [1:0] hmode = 2'b00;
  logic       vmode, locked, trs_f, trs_v, trs_h;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  bt656_std_detect i_bt656_std_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .auto_en(auto_en), .hmode(hmode),
    .vmode(vmode), .locked(locked), .trs_f(trs_f), .trs_v(trs_v), .trs_h(trs_h)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h10;
  endtask

  task automatic send_code(input logic [7:0] xy);
    send_byte(8'hFF);
    send_byte(8'h00);
    send_byte(8'h00);
    send_byte(xy);
  endtask

  // End code (H=1), blank bytes, start code (H=0), short active part
  task automatic send_line(input int blank, input bit gaps);
    send_code(8'h90);
    for (int i = 0; i < blank; i++) begin
      send_byte(i[0] ? 8'h10 : 8'h80);
      if (gaps && (i % 7 == 0)) begin
        in_data = 8'hFF;
        @(negedge clk);
        in_data = 8'h00;
        @(negedge clk);
        in_data = 8'h10;
      end
    end
    if (gaps) begin
      send_byte(8'hFF);
      in_data = 8'h00;
      @(negedge clk);
      send_byte(8'h00);
      send_byte(8'h00);
      send_byte(8'h80);
    end else begin
      send_code(8'h80);
    end
    for (int i = 0; i < 8; i++) send_byte(8'h40 + 8'(i));
  endtask

  task automatic t_reset();
    check("R8 vmode after reset", vmode, 0);
    check("R8 locked after reset", locked, 0);
    check("R8 flags after reset", {trs_f, trs_v, trs_h}, 0);
    check("R1 ready", in_ready, 1);
  endtask

  task automatic t_flags();
    send_code(8'hB0);
    check("R2 flags F/V/H from XY B0", {trs_f, trs_v, trs_h}, 3'b011);
    send_code(8'h70);
    check("R2 XY bit7=0 ignored", {trs_f, trs_v, trs_h}, 3'b011);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'hE0);
    check("R2 short preamble ignored", {trs_f, trs_v, trs_h}, 3'b011);
    send_code(8'hC0);
    check("R2 flags from XY C0", {trs_f, trs_v, trs_h}, 3'b100);
    check("R6 short length no lock", locked, 0);
  endtask

  task automatic t_lock525();
    for (int l = 0; l < 3; l++) begin
      send_line(268, 1'b0);
      check("R5 vmode before 4th line", vmode, 0);
      check("R6 not locked before 4th line", locked, 0);
    end
    send_line(268, 1'b0);
    check("R5 vmode 525 after 4 lines", vmode, 1);
    check("R6 locked after 4 lines", locked, 1);
    check("R2 flags after line", {trs_f, trs_v, trs_h}, 3'b000);
  endtask

  task automatic t_windows();
    send_line(266, 1'b0);
    check("R4 266 in 525 window", locked, 1);
    send_line(270, 1'b0);
    check("R4 270 in 525 window", locked, 1);
    send_line(265, 1'b0);
    check("R4 265 outside windows unlocks", locked, 0);
    check("R6 vmode held on no match", vmode, 1);
    send_line(278, 1'b0);
    send_line(282, 1'b0);
    send_line(280, 1'b0);
    check("R5 vmode held after 3 lines 625", vmode, 1);
    send_line(279, 1'b0);
    check("R5 vmode 625 after 4 lines", vmode, 0);
    check("R6 locked on 625", locked, 1);
    send_line(283, 1'b0);
    check("R4 283 outside window unlocks", locked, 0);
    send_line(271, 1'b0);
    check("R4 271 outside window", locked, 0);
    check("R4 vmode unchanged", vmode, 0);
  endtask

  task automatic t_gaps();
    for (int l = 0; l < 4; l++) send_line(268, 1'b1);
    check("R1 idle bytes not counted, vmode", vmode, 1);
    check("R1 idle bytes not counted, locked", locked, 1);
    send_line(280, 1'b0);
    check("R6 other standard clears lock", locked, 0);
    for (int l = 0; l < 4; l++) send_line(268, 1'b0);
    check("R6 relocked on 525", locked, 1);
  endtask

  task automatic t_lone_sav();
    for (int i = 0; i < 20; i++) send_byte(8'h80);
    send_code(8'h80);
    check("R3 start code without end code ignored", locked, 1);
    check("R3 vmode unchanged", vmode, 1);
    send_line(268, 1'b0);
    check("R3 measurement after lone start code", locked, 1);
  endtask

  task automatic t_disable();
    auto_en = 1'b0;
    @(negedge clk);
    check("R7 disable clears lock next cycle", locked, 0);
    for (int l = 0; l < 4; l++) send_line(280, 1'b0);
    check("R7 vmode held while disabled", vmode, 1);
    check("R7 locked low while disabled", locked, 0);
    auto_en = 1'b1;
    hmode = 2'b01;
    for (int l = 0; l < 4; l++) send_line(280, 1'b0);
    check("R7 vmode held with hmode 01", vmode, 1);
    check("R7 locked low with hmode 01", locked, 0);
    hmode = 2'b00;
    for (int l = 0; l < 3; l++) send_line(280, 1'b0);
    check("R7 fresh run needed after enable", vmode, 1);
    send_line(280, 1'b0);
    check("R7 vmode 625 after fresh run", vmode, 0);
    // Run broken by a one-cycle disable
    send_line(268, 1'b0);
    send_line(268, 1'b0);
    auto_en = 1'b0;
    @(negedge clk);
    auto_en = 1'b1;
    send_line(268, 1'b0);
    send_line(268, 1'b0);
    check("R7 run restarted by disable pulse", vmode, 0);
    send_line(268, 1'b0);
    send_line(268, 1'b0);
    check("R7 vmode 525 after restarted run", vmode, 1);
    check("R6 locked after restarted run", locked, 1);
  endtask

  task automatic t_saturate();
    send_line(4364, 1'b0);
    check("R4 counter saturates, no match", locked, 0);
    check("R4 vmode held on overflow", vmode, 1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flags();
    t_lock525();
    t_windows();
    t_gaps();
    t_lone_sav();
    t_disable();
    t_saturate();
    finish_run();
  end

endmodule